// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Detector

This block watches a UART receive FIFO and flags when words have been sitting in it with no new arrival for a programmed number of baud-rate ticks. A 7-bit idle counter advances on baud ticks while the FIFO holds data. It restarts from zero when a new word lands, and it is cleared when a read drains the FIFO. When the count reaches the programmed compare value, a sticky status flag is set. An interrupt line follows that flag only while the interrupt mask bit is set.

The counter is gated by its own enable bit. It stops at the compare value, so each idle period raises the event only once. Software clears the flag through a one-cycle clear input. The FIFO storage, the receive shifter and the register decode live outside. The `fifo_empty` input must show FIFO occupancy as it stands after any push or pop in the same cycle.

Top module: `rxto_idle_timeout`

## Requirements
- R1: After reset the status flag and the interrupt line are 0 and the idle count is zero, so the first timeout needs a full compare-value run of ticks.
- R2: While `cfg_en` is 0 the counter is held at zero and no timeout is raised, whatever ticks arrive.
- R3: With `cfg_en` 1 and `fifo_empty` 0, the count rises by exactly one for each cycle in which `baud_tick` is 1. Ticks while `fifo_empty` is 1 change nothing.
- R4: A cycle with `rx_push` 1 clears the count. The flag is set exactly `cfg_cmp` baud ticks after the last pushed word, and not after `cfg_cmp`-1 ticks.
- R5: A cycle with `rx_pop` 1 and `fifo_empty` 1 (a read that empties the FIFO) clears the count.
- R6: The flag becomes 1 at the clock edge of the tick that brings the count to `cfg_cmp`. It then stays 1 until a cycle with `sts_clr` 1. If a new timeout event and a clear fall in the same cycle, the event wins.
- R7: The count stops at `cfg_cmp`, so after the flag is cleared, further ticks do not set it again until a new word restarts the idle period.
- R8: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1. The flag itself is set regardless of `irq_en`.
- R9: A compare value of 0 never raises a timeout.
- R10: When `rx_push` and `baud_tick` are 1 in the same cycle, the clear wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle baud-rate tick |
| rx_push | input | 1 | A new word was written into the receive FIFO this cycle |
| rx_pop | input | 1 | A word was read from the receive FIFO this cycle |
| fifo_empty | input | 1 | FIFO is empty after this cycle's push or pop |
| cfg_en | input | 1 | Idle counter enable |
| cfg_cmp | input | CNT_W | Timeout compare value in baud ticks |
| irq_en | input | 1 | Interrupt mask for the timeout flag |
| sts_clr | input | 1 | Clears the timeout flag |
| sts_timeout | output | 1 | Sticky timeout status flag |
| irq | output | 1 | Masked timeout interrupt |

## Verification
The bench builds the block at its default 7-bit counter width. That width makes an exhaustive sweep of every compare value from 0 to 127 cheap. For each value, the bench checks the flag one tick before and exactly at the expected tick, with the interrupt mask alternating between runs. The small width also puts the top compare value and the zero case within reach. The bench adds directed runs for disabled counting, draining reads, restarts by new words, a push and tick in the same cycle, ticks while empty, and a clear that collides with a new event.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    // Why the idle counter is forced to zero this cycle
    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_OFF   = 2'd1,
        CLR_PUSH  = 2'd2,
        CLR_DRAIN = 2'd3
    } clr_cause_e;

    localparam int RXTO_DEF_CNT_W = 7;

endpackage

// File: rtl/rxto_counter.sv
module rxto_counter
    import rxto_pkg::*;
#(
    parameter int CNT_W = RXTO_DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             fifo_empty,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    clr_cause_e cause;
    logic       step;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        if (!cnt_en)                    cause = CLR_OFF;
        else if (rx_push)               cause = CLR_PUSH;
        else if (rx_pop && fifo_empty)  cause = CLR_DRAIN;
        else                            cause = CLR_NONE;
    end

    always_comb begin
        state_d = state_q;
        cnt_inc = state_q.cnt + 1'b1;
        // Count only with data waiting and below the compare value
        step    = (cause == CLR_NONE) && baud_tick && !fifo_empty
                  && (state_q.cnt < cmp);
        hit     = 1'b0;
        if (cause != CLR_NONE) begin
            state_d.cnt = '0;
        end else if (step) begin
            state_d.cnt = cnt_inc;
            hit         = (cnt_inc == cmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R2: disabled counter sits at zero
    assert_off_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> state_q.cnt == '0);
    // R4 / R10: a new word restarts the count, even with a tick
    assert_push_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && rx_push) |=> state_q.cnt == '0);
    // R5: draining read clears the count
    assert_drain_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !rx_push && rx_pop && fifo_empty) |=> state_q.cnt == '0);
    // R3: without a tick or clear the count holds
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !rx_push && !(rx_pop && fifo_empty) && !baud_tick)
        |=> $stable(state_q.cnt));
    // R7: at or past the compare value the count stops
    assert_stop_at_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !rx_push && !(rx_pop && fifo_empty) && state_q.cnt >= cmp)
        |=> $stable(state_q.cnt));
    // R9: zero compare never produces an event
    assert_zero_cmp_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0) |-> !hit);

endmodule

// File: rtl/rxto_status.sv
module rxto_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic sts_clr,
    input  logic irq_en,
    output logic sts,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } sts_state_t;

    sts_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (hit)          state_d.flag = 1'b1;   // event wins over clear
        else if (sts_clr) state_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sts = state_q.flag;
    assign irq = state_q.flag & irq_en;

    // R6: an event sets the flag on the next edge
    assert_set_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sts);
    // R6: flag is sticky without a clear
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !sts_clr) |=> sts);
    // R6: a clear without an event drops the flag
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !hit) |=> !sts);

endmodule

// File: rtl/rxto_idle_timeout.sv
module rxto_idle_timeout
    import rxto_pkg::*;
#(
    parameter int CNT_W = RXTO_DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             fifo_empty,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic             irq_en,
    input  logic             sts_clr,
    output logic             sts_timeout,
    output logic             irq
);

    logic hit;

    rxto_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .fifo_empty (fifo_empty),
        .cnt_en     (cfg_en),
        .cmp        (cfg_cmp),
        .hit        (hit)
    );

    rxto_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .sts_clr (sts_clr),
        .irq_en  (irq_en),
        .sts     (sts_timeout),
        .irq     (irq)
    );

    // R8: interrupt never fires while masked
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en) |-> !irq);

endmodule

// File: tb/tb_rxto_idle_timeout.sv
`timescale 1ns/1ps
module tb_rxto_idle_timeout;

    localparam int CNT_W = 7;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 0, rx_push = 0, rx_pop = 0, fifo_empty = 1;
    logic cfg_en = 0, irq_en = 0, sts_clr = 0;
    logic [CNT_W-1:0] cfg_cmp = '0;
    logic sts_timeout, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rxto_idle_timeout #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_push(rx_push),
        .rx_pop(rx_pop), .fifo_empty(fifo_empty), .cfg_en(cfg_en),
        .cfg_cmp(cfg_cmp), .irq_en(irq_en), .sts_clr(sts_clr),
        .sts_timeout(sts_timeout), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // each task spans one clock edge; inputs change on the falling edge
    task automatic idle();
        @(negedge clk);
        baud_tick = 0; rx_push = 0; rx_pop = 0; sts_clr = 0;
    endtask

    task automatic cyc(input logic t, input logic p, input logic r, input logic c);
        @(negedge clk);
        baud_tick = t; rx_push = p; rx_pop = r; sts_clr = c;
        @(negedge clk);
        baud_tick = 0; rx_push = 0; rx_pop = 0; sts_clr = 0;
    endtask

    task automatic push_word();
        @(negedge clk);
        fifo_empty = 0; rx_push = 1;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    endtask

    task automatic clear_flag();
        cyc(0, 0, 0, 1);
    endtask

    task automatic drain();
        @(negedge clk);
        fifo_empty = 1; rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sts_timeout, 1'b0, "R1 flag at reset");
        check(irq, 1'b0, "R1 irq at reset");
        rst_n = 1;
        idle();
        cfg_en = 1;
        cfg_cmp = 3;
        push_word();
        ticks(2);
        check(sts_timeout, 1'b0, "R1 no early timeout after reset");
        ticks(1);
        check(sts_timeout, 1'b1, "R1 full run after reset");
        clear_flag();
        drain();

        // R4/R6/R8 exhaustive sweep of compare values
        for (int c = 1; c <= MAXC; c++) begin
            cfg_cmp = c[CNT_W-1:0];
            irq_en  = c[0];
            push_word();
            ticks(c - 1);
            check(sts_timeout, 1'b0, $sformatf("R4 cmp=%0d one tick early", c));
            ticks(1);
            check(sts_timeout, 1'b1, $sformatf("R6 cmp=%0d flag at cmp", c));
            check(irq, c[0], $sformatf("R8 cmp=%0d irq mask", c));
            ticks(2);
            check(sts_timeout, 1'b1, $sformatf("R6 cmp=%0d sticky", c));
            clear_flag();
            check(sts_timeout, 1'b0, $sformatf("R6 cmp=%0d cleared", c));
            ticks(3);
            check(sts_timeout, 1'b0, $sformatf("R7 cmp=%0d fires once", c));
            drain();
        end

        // R9: compare 0 never fires
        cfg_cmp = 0; irq_en = 1;
        push_word();
        ticks(140);
        check(sts_timeout, 1'b0, "R9 cmp=0 silent");
        drain();

        // R2: disabled counter
        cfg_cmp = 5; cfg_en = 0;
        push_word();
        ticks(10);
        check(sts_timeout, 1'b0, "R2 disabled no timeout");
        cfg_en = 1;
        ticks(4);
        check(sts_timeout, 1'b0, "R2 count restarts at zero on enable");
        ticks(1);
        check(sts_timeout, 1'b1, "R2 fires after enable run");
        clear_flag();

        // R5: draining read before the compare value
        push_word();
        ticks(4);
        drain();
        ticks(10);
        check(sts_timeout, 1'b0, "R5 drained fifo no timeout");
        // R3: ticks while empty ignored; count continues once data arrives
        push_word();
        ticks(2);
        fifo_empty = 1; idle();
        ticks(6);
        check(sts_timeout, 1'b0, "R3 empty ticks ignored");
        fifo_empty = 0; idle();
        ticks(2);
        check(sts_timeout, 1'b0, "R3 resume one short");
        ticks(1);
        check(sts_timeout, 1'b1, "R3 resume reaches cmp");
        clear_flag();
        drain();

        // R4: new word restarts idle window
        push_word();
        ticks(4);
        push_word();
        ticks(4);
        check(sts_timeout, 1'b0, "R4 restart by new word");
        ticks(1);
        check(sts_timeout, 1'b1, "R4 timeout from last word");
        // R8: masked irq with flag set
        irq_en = 0; idle();
        check(irq, 1'b0, "R8 irq masked");
        irq_en = 1; idle();
        check(irq, 1'b1, "R8 irq unmasked");
        clear_flag();

        // R10: push with tick in the same cycle
        push_word();
        ticks(2);
        cyc(1, 1, 0, 0);
        ticks(4);
        check(sts_timeout, 1'b0, "R10 push beats tick");
        ticks(1);
        check(sts_timeout, 1'b1, "R10 fires after full run");
        clear_flag();

        // R6: clear colliding with new event, event wins
        push_word();
        ticks(4);
        cyc(1, 0, 0, 1);
        check(sts_timeout, 1'b1, "R6 event beats clear");
        clear_flag();
        check(sts_timeout, 1'b0, "R6 cleared afterwards");
        drain();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule